// File: doc/BRIEF.md
# Directory Header Checksum and Signature Validator

This block checks the header entry at the start of the directory sector on a backup memory. The memory delivers the sector as a stream of bytes, one byte on each cycle where the strobe is high. The block counts the bytes and keeps a running 16-bit additive checksum. That checksum covers every byte from offset 2 to the end of the sector. The block compares the checksum with the value stored in the first two bytes. It also checks ten bytes at offsets 4 to 13 against a fixed signature.

When the final byte of the sector arrives, the block raises a done flag. With it come a pass flag, separate flags for checksum failure and signature failure, and the total sector count read from bytes 2 and 3. A controller pulses the start input before each sector. Issuing the memory reads, deciding when to retry and parsing the directory entries are left to other logic.

Top module: `dir_hdr_validator`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), done, pass, sum_fail and sig_fail are 0 and sector_count is 0.
- R2: The checksum is the sum, modulo 65536, of all sector bytes at offsets 2 to SECTOR_BYTES-1. It is compared with the stored value {byte 1, byte 0}, where byte 0 is the low half. When done is 1, sum_fail is 1 exactly when the two differ. Bytes 0 and 1 are not part of the sum.
- R3: The bytes at offsets 4 to 13 must equal, in offset order, D2 D3 D8 CD DE B0 BD 31 32 38 (hex). When done is 1, sig_fail is 1 exactly when at least one of them differs.
- R4: When done is 1, pass is 1 exactly when both sum_fail and sig_fail are 0.
- R5: done becomes 1 at the clock edge that accepts byte SECTOR_BYTES-1, so it is visible in the cycle after that byte is presented. While done is 0, pass, sum_fail and sig_fail are all 0.
- R6: sector_count equals {byte 3, byte 2}, where byte 2 is the low half. It is captured as those bytes arrive and is valid once done is 1.
- R7: While done is 1 and start is low, strobed bytes are ignored, and done, the result flags and sector_count hold their values.
- R8: A start pulse clears done, the flags, sector_count, the byte position and the accumulator. A byte strobed in the same cycle as start is dropped, and the next accepted byte is offset 0.
- R9: Cycles with byte_vld low do not advance the byte position, so gaps in the stream leave the result unchanged.
- R10: The accumulator wraps modulo 65536. A sector whose byte total exceeds 65535 passes when the stored checksum holds the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears all state before a new sector |
| byte_vld | input | 1 | Strobe: byte_data carries the next sector byte |
| byte_data | input | 8 | Sector byte |
| done | output | 1 | Whole sector has been received |
| pass | output | 1 | Checksum and signature both correct |
| sum_fail | output | 1 | Checksum mismatch |
| sig_fail | output | 1 | Signature mismatch |
| sector_count | output | 16 | Total sector count taken from bytes 2 and 3 |

## Verification
The bench applies several sector patterns, each chosen to separate one condition from the others.
- A freshly formatted header, whose stored sum is 0x0630 and whose other bytes are zero, must pass.
- One stored-sum byte is changed. This must raise only the checksum flag, which shows that bytes 0 and 1 stay out of the sum.
- A count byte is changed while the stored sum is left as it was. This shows that bytes 2 and 3 are part of the sum.
- One signature byte is changed and the sum is recomputed to match. This must raise only the signature flag.
- A sector filled with 0xFF is streamed with idle gaps. Its total goes well past 16 bits, so it exercises wrap-around and gap tolerance, and it carries a nonzero count.
- Strobes sent after done must leave every output unchanged.
- A restart in the middle of a sector, with a byte strobed in the same cycle as start, must still give a clean pass on the next full sector.

// File: rtl/hv_pkg.sv
// Package hv_pkg
// Shared constants for the directory header validator.
// Assumes a signature of fixed length that is placed at a fixed offset.
package hv_pkg;
    localparam int SIG_OFFSET = 4;
    localparam int SIG_LEN    = 10;

    // Returns the expected signature byte at window index k.
    function automatic logic [7:0] sig_byte(input int unsigned k);
        case (k)
            0:       sig_byte = 8'hD2;
            1:       sig_byte = 8'hD3;
            2:       sig_byte = 8'hD8;
            3:       sig_byte = 8'hCD;
            4:       sig_byte = 8'hDE;
            5:       sig_byte = 8'hB0;
            6:       sig_byte = 8'hBD;
            7:       sig_byte = 8'h31;
            8:       sig_byte = 8'h32;
            default: sig_byte = 8'h38;
        endcase
    endfunction
endpackage

// File: rtl/hv_pos_counter.sv
// Module hv_pos_counter
// Tracks the offset of the next byte within the sector.
// Assumes the owner stops advancing it after the last byte.
module hv_pos_counter #(
    parameter int N = 1024,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] pos,
    output logic         last
);
    localparam logic [W-1:0] LAST_POS = W'(N - 1);

    // Moves the position forward once for each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pos <= '0;
        else if (adv)      pos <= pos + 1'b1;
    end

    assign last = (pos == LAST_POS);
endmodule

// File: rtl/hv_sum_acc.sv
// Module hv_sum_acc
// 16-bit additive accumulator that wraps modulo 2^16.
// Assumes the owner asserts add only for the bytes that belong in the sum.
module hv_sum_acc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        add,
    input  logic [7:0]  din,
    output logic [15:0] acc_nxt
);
    logic [15:0] acc;

    // Forms the sum that includes the byte now on the input.
    always_comb acc_nxt = acc + {8'h00, din};

    // Registers the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (add)      acc <= acc_nxt;
    end
endmodule

// File: rtl/hv_sig_cmp.sv
// Module hv_sig_cmp
// Compares the bytes inside the signature window with the constant signature
// and keeps a sticky mismatch flag.
// Assumes pos is the offset of the byte currently on din.
module hv_sig_cmp #(
    parameter int N = 1024,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] pos,
    input  logic [7:0]   din,
    output logic         bad_nxt
);
    import hv_pkg::*;

    localparam logic [W-1:0] LO = W'(SIG_OFFSET);
    localparam logic [W-1:0] HI = W'(SIG_OFFSET + SIG_LEN);

    logic         bad;
    logic         in_win;
    logic [W-1:0] rel;

    // Finds the window position and flags a mismatching byte.
    always_comb begin
        in_win  = (pos >= LO) && (pos < HI);
        rel     = pos - LO;
        bad_nxt = bad | (adv && in_win && (din != sig_byte(int'(rel))));
    end

    // Keeps the mismatch flag until the next clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) bad <= 1'b0;
        else               bad <= bad_nxt;
    end
endmodule

// File: rtl/dir_hdr_validator.sv
// Module dir_hdr_validator
// Validates the directory header sector streamed in one byte per strobe. It
// checks the additive checksum and the fixed signature, and holds the results
// until the next start pulse.
// Assumes SECTOR_BYTES >= 14 and that start is pulsed before each sector.
module dir_hdr_validator #(
    parameter int SECTOR_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    output logic        done,
    output logic        pass,
    output logic        sum_fail,
    output logic        sig_fail,
    output logic [15:0] sector_count
);
    localparam int W = $clog2(SECTOR_BYTES);
    localparam logic [W-1:0] P_SUM_LO = W'(0);
    localparam logic [W-1:0] P_SUM_HI = W'(1);
    localparam logic [W-1:0] P_CNT_LO = W'(2);
    localparam logic [W-1:0] P_CNT_HI = W'(3);

    logic         accept;
    logic [W-1:0] pos;
    logic         last;
    logic [15:0]  acc_nxt;
    logic         sig_bad_nxt;
    logic [15:0]  stored_sum;
    logic         sum_bad;

    // A byte is taken only while the sector is open and no restart is pending.
    always_comb accept = byte_vld && !done && !start;

    hv_pos_counter #(.N(SECTOR_BYTES)) u_pos (
        .clk(clk), .rst_n(rst_n), .clr(start), .adv(accept),
        .pos(pos), .last(last)
    );

    hv_sum_acc u_acc (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .add(accept && (pos >= P_CNT_LO)), .din(byte_data),
        .acc_nxt(acc_nxt)
    );

    hv_sig_cmp #(.N(SECTOR_BYTES)) u_sig (
        .clk(clk), .rst_n(rst_n), .clr(start), .adv(accept),
        .pos(pos), .din(byte_data), .bad_nxt(sig_bad_nxt)
    );

    // Captures the stored checksum and the sector count as their bytes arrive.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            stored_sum   <= '0;
            sector_count <= '0;
        end else if (accept) begin
            if (pos == P_SUM_LO) stored_sum[7:0]    <= byte_data;
            if (pos == P_SUM_HI) stored_sum[15:8]   <= byte_data;
            if (pos == P_CNT_LO) sector_count[7:0]  <= byte_data;
            if (pos == P_CNT_HI) sector_count[15:8] <= byte_data;
        end
    end

    // Compares the final sum, which includes the last byte, with the stored value.
    always_comb sum_bad = (acc_nxt != stored_sum);

    // Latches the verdict when the final byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            done     <= 1'b0;
            pass     <= 1'b0;
            sum_fail <= 1'b0;
            sig_fail <= 1'b0;
        end else if (accept && last) begin
            done     <= 1'b1;
            sum_fail <= sum_bad;
            sig_fail <= sig_bad_nxt;
            pass     <= !sum_bad && !sig_bad_nxt;
        end
    end
endmodule

// File: rtl/hv_checker.sv
// Module hv_checker
// Checks port-level properties of dir_hdr_validator. It is attached to the
// top module by the bind statement at the end of this file.
module hv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        byte_vld,
    input logic        done,
    input logic        pass,
    input logic        sum_fail,
    input logic        sig_fail,
    input logic [15:0] sector_count
);
    // R5: no verdict flag is shown before the sector is complete.
    a_r5_flags_low_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(pass || sum_fail || sig_fail));

    // R4: pass is the complement of any failure.
    a_r4_pass_iff_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass == !(sum_fail || sig_fail)));

    // R8: a start pulse reopens the sector.
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    // R7: results hold while no restart is requested.
    a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(sum_fail)
                              && $stable(sig_fail) && $stable(sector_count)));

    // R9: without a strobe the sector cannot complete.
    a_r9_no_done_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !byte_vld) |=> !done);
endmodule

bind dir_hdr_validator hv_checker u_hv_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_vld(byte_vld),
    .done(done), .pass(pass), .sum_fail(sum_fail), .sig_fail(sig_fail),
    .sector_count(sector_count)
);

// File: tb/tb_dir_hdr_validator.sv
module tb_dir_hdr_validator;
    localparam int N = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        byte_vld;
    logic [7:0]  byte_data;
    logic        done, pass, sum_fail, sig_fail;
    logic [15:0] sector_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Behavioural reference model state.
    logic [7:0]  q[$];
    logic        m_done, m_pass, m_sf, m_gf;
    logic [7:0]  sec [N];
    logic [7:0]  sig_ref [10] = '{8'hD2, 8'hD3, 8'hD8, 8'hCD, 8'hDE,
                                  8'hB0, 8'hBD, 8'h31, 8'h32, 8'h38};

    always #10 clk = ~clk;

    dir_hdr_validator #(.SECTOR_BYTES(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_vld(byte_vld),
        .byte_data(byte_data), .done(done), .pass(pass), .sum_fail(sum_fail),
        .sig_fail(sig_fail), .sector_count(sector_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_count();
        logic [7:0] lo, hi;
        lo = (q.size() > 2) ? q[2] : 8'h00;
        hi = (q.size() > 3) ? q[3] : 8'h00;
        return {hi, lo};
    endfunction

    task automatic model_step(input logic s, input logic v, input logic [7:0] d);
        if (s) begin
            q.delete();
            m_done = 0; m_pass = 0; m_sf = 0; m_gf = 0;
        end else if (v && !m_done) begin
            q.push_back(d);
            if (q.size() == N) begin
                logic [15:0] sum;
                sum = 16'h0;
                for (int i = 2; i < N; i++) sum = sum + 16'(q[i]);
                m_sf = (sum != {q[1], q[0]});
                m_gf = 0;
                for (int k = 0; k < 10; k++) if (q[4 + k] != sig_ref[k]) m_gf = 1;
                m_pass = !m_sf && !m_gf;
                m_done = 1;
            end
        end
    endtask

    // Drives one cycle, advances the model and compares every output.
    task automatic cyc(input logic s, input logic v, input logic [7:0] d);
        start = s; byte_vld = v; byte_data = d;
        @(posedge clk);
        model_step(s, v, d);
        @(negedge clk);
        check("R5 done", done, m_done);
        check("R4 pass", pass, m_pass);
        check("R2 sum_fail", sum_fail, m_sf);
        check("R3 sig_fail", sig_fail, m_gf);
        check("R6 sector_count", sector_count, m_count());
    endtask

    task automatic build(input logic [15:0] cnt, input logic [7:0] fillv);
        for (int i = 0; i < N; i++) sec[i] = fillv;
        sec[2] = cnt[7:0];
        sec[3] = cnt[15:8];
        for (int k = 0; k < 10; k++) sec[4 + k] = sig_ref[k];
    endtask

    task automatic seal();
        logic [15:0] s;
        s = 16'h0;
        for (int i = 2; i < N; i++) s = s + 16'(sec[i]);
        sec[0] = s[7:0];
        sec[1] = s[15:8];
    endtask

    task automatic send(input bit gaps);
        cyc(1, 0, 8'h00);
        for (int i = 0; i < N; i++) begin
            if (gaps && (i % 7 == 3)) cyc(0, 0, 8'hA5);
            cyc(0, 1, sec[i]);
        end
    endtask

    initial begin
        rst_n = 0; start = 0; byte_vld = 0; byte_data = 0;
        m_done = 0; m_pass = 0; m_sf = 0; m_gf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R1 done", done, 0);
        check("R1 pass", pass, 0);
        check("R1 sum_fail", sum_fail, 0);
        check("R1 sig_fail", sig_fail, 0);
        check("R1 sector_count", sector_count, 0);

        // Formatted empty header: the stored sum must be 0x0630.
        build(16'h0000, 8'h00); seal();
        check("R2 formatted sum", {sec[1], sec[0]}, 16'h0630);
        send(0);
        check("R4 formatted header passes", pass, 1);

        // Stored-sum byte altered: only the checksum flag must rise.
        build(16'h0000, 8'h00); seal(); sec[0] = 8'h31;
        send(0);
        check("R2 sum byte excluded", {sum_fail, sig_fail, pass}, 3'b100);

        // Count byte altered without resealing: the count is part of the sum.
        build(16'h0000, 8'h00); seal(); sec[3] = 8'h01;
        send(0);
        check("R2 count in sum", sum_fail, 1);

        // Signature byte at offset 9 altered and resealed.
        build(16'h0000, 8'h00); sec[9] = 8'hDF; seal();
        send(0);
        check("R3 signature only", {sum_fail, sig_fail, pass}, 3'b010);

        // Sector of 0xFF bytes with idle gaps: the sum wraps past 16 bits.
        build(16'h1234, 8'hFF); seal();
        send(1);
        check("R10 wrap pass", pass, 1);
        check("R9 gaps tolerated", done, 1);
        check("R6 count", sector_count, 16'h1234);

        // Strobes after done are ignored.
        for (int i = 0; i < 5; i++) cyc(0, 1, 8'h55);
        check("R7 held count", sector_count, 16'h1234);
        check("R7 held pass", pass, 1);

        // Restart in mid-sector, with a byte strobed together with start.
        build(16'h0000, 8'h00); seal();
        cyc(1, 0, 8'h00);
        for (int i = 0; i < 100; i++) cyc(0, 1, 8'h77);
        cyc(1, 1, 8'h99);
        check("R8 start clears done", done, 0);
        check("R8 start clears count", sector_count, 0);
        for (int i = 0; i < N; i++) cyc(0, 1, sec[i]);
        check("R8 clean pass after restart", pass, 1);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule